// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block decides which 5-bit frequency code a clock synthesizer runs from. While the low-active power-good strobe is held low, it samples five frequency-select straps, a mode strap and a 24/48 MHz select strap. The latched straps stay frozen once the strobe releases. The cycle after release, the latched straps load automatically as the first active code. After that, the active code changes only on an update strobe or on a watchdog timeout.

On an update strobe, a software-enable bit picks the source of the new code: the latched straps, or a 5-bit software field. On a watchdog timeout the block forces a fallback code and switches off direct M/N programming. The fallback comes from the latched straps or from a 5-bit safe field, as a safe-reload bit selects. A selected code that is reserved is never applied. The previous code stays in force and a sticky error flag is raised.

From the active code the block derives two outputs: a CPU output divider ratio for a nominal 800 MHz VCO, and a 2-bit reference trim group. When direct programming is enabled, an update strobe also captures the loop multiplier N+4 and the divider M.

Top module: `fsel_ctrl`

## Requirements
- R1: While `pwrgd_n` is 0, each rising clock edge copies `strap_fs` into the latched straps. While it is 1, they hold their value. `strap_rb` always shows the latched straps.
- R2: On the first clock edge at which `pwrgd_n` is 1 after being 0, `act_code` takes the latched straps.
- R3: On a clock edge with `upd` = 1, the selected code is `sw_code` if `sw_en` = 1, and the latched straps if `sw_en` = 0.
- R4: A code is reserved when bits [1:0] are 11, or when bit 3 and bit 2 are both 1. `act_code` never holds a reserved code.
- R5: If the code selected at a load event is reserved, `act_code` keeps its value and `code_err` is set. `code_err` stays set until an `err_clr` edge with no new reserved load; a set in the same edge wins over the clear. `sel_rsvd` shows whether the code selected by the current inputs is reserved.
- R6: While `pwrgd_n` is 0, `mode_bit` and `sel24_bit` follow `strap_mode` and `strap_sel24`, and their write enables have no effect. While `pwrgd_n` is 1, a write enable loads the write value.
- R7: On an edge with `wd_timeout` = 1, the following happen:
  - `direct_en`, `pll_num` and `pll_den` clear to 0.
  - The selected code is `safe_code` if `safe_en` = 1, otherwise the latched straps.
  - The timeout takes priority over the power-good release and over `upd`.
- R8: `dp_wr_en` loads `dp_wr_val` into `direct_en`. An `upd` edge while `direct_en` = 1 captures `n_val`+4 into `pll_num` and `m_val` into `pll_den`.
- R9: `cpu_div` decodes `act_code[2:0]` as 000→8, 001→4, 010→6, 100→4, 101→2, 110→3. `trim_sel` is 0 when bit 3 is 0; otherwise it is 1 when bit 4 is 0 and 2 when bit 4 is 1.
- R10: `act_code` changes only at edges carrying a power-good release, an `upd` or a `wd_timeout`. After reset it is 00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwrgd_n | input | 1 | Power-good strobe, low-active; straps sampled while low |
| strap_fs | input | 5 | Frequency-select straps |
| strap_mode | input | 1 | Mode strap |
| strap_sel24 | input | 1 | 24/48 MHz select strap |
| mode_wr_en | input | 1 | Software write enable for the mode bit |
| mode_wr_val | input | 1 | Software value for the mode bit |
| sel24_wr_en | input | 1 | Software write enable for the 24/48 bit |
| sel24_wr_val | input | 1 | Software value for the 24/48 bit |
| sw_en | input | 1 | 1: update uses sw_code, 0: latched straps |
| sw_code | input | 5 | Software frequency code |
| safe_en | input | 1 | 1: timeout uses safe_code, 0: latched straps |
| safe_code | input | 5 | Safe fallback code |
| upd | input | 1 | Registered update strobe |
| wd_timeout | input | 1 | Watchdog reload request |
| err_clr | input | 1 | Clears the sticky error flag |
| dp_wr_en | input | 1 | Write enable for the direct-programming bit |
| dp_wr_val | input | 1 | Value for the direct-programming bit |
| m_val | input | 7 | Direct-programming divider M |
| n_val | input | 10 | Direct-programming value N |
| act_code | output | 5 | Active frequency code |
| cpu_div | output | 4 | CPU output divider ratio |
| trim_sel | output | 2 | Reference trim group |
| code_err | output | 1 | Sticky reserved-code flag |
| sel_rsvd | output | 1 | Currently selected code is reserved |
| strap_rb | output | 5 | Latched strap readback |
| mode_bit | output | 1 | Mode configuration bit |
| sel24_bit | output | 1 | 24/48 configuration bit |
| direct_en | output | 1 | Direct M/N programming active |
| pll_num | output | 11 | Captured N+4 |
| pll_den | output | 7 | Captured M |

## Verification
The assertions assume that `pwrgd_n`, the strobes and the register fields are synchronous to `clk`. They also assume that a reset precedes any use, so that the registers start from a legal code. They do not assume that inputs avoid reserved codes, since rejecting those codes is a checked behaviour. The stimulus changes every input on the falling edge and holds each strobe high for exactly one rising edge. It releases `pwrgd_n` only after the straps have settled, so every load event can be tied to a single edge.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int CODE_W = 5;
  localparam int DIV_W  = 4;
  localparam int TRIM_W = 2;
  typedef logic [CODE_W-1:0] code_t;

  function automatic logic code_reserved(input code_t c);
    return (c[1:0] == 2'b11) || (c[3] && c[2]);
  endfunction

  function automatic logic [DIV_W-1:0] cpu_ratio(input code_t c);
    logic [DIV_W-1:0] r;
    case (c[2:0])
      3'b000:  r = 4'd8;
      3'b001:  r = 4'd4;
      3'b010:  r = 4'd6;
      3'b100:  r = 4'd4;
      3'b101:  r = 4'd2;
      3'b110:  r = 4'd3;
      default: r = 4'd0;
    endcase
    return r;
  endfunction

  function automatic logic [TRIM_W-1:0] trim_of(input code_t c);
    logic [TRIM_W-1:0] t;
    if (!c[3])     t = 2'd0;
    else if (c[4]) t = 2'd2;
    else           t = 2'd1;
    return t;
  endfunction
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
  import fsel_pkg::*;
#(
  parameter int NCFG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwrgd_n,
  input  code_t           strap_fs,
  input  logic [NCFG-1:0] cfg_strap,
  input  logic [NCFG-1:0] cfg_wr_en,
  input  logic [NCFG-1:0] cfg_wr_val,
  output code_t           strap_q,
  output logic [NCFG-1:0] cfg_q,
  output logic            boot_load
);
  logic pwrgd_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q   <= '0;
      pwrgd_n_d <= 1'b0;
    end else begin
      pwrgd_n_d <= pwrgd_n;
      if (!pwrgd_n) strap_q <= strap_fs;
    end
  end

  assign boot_load = pwrgd_n && !pwrgd_n_d;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cfg_q[g] <= 1'b0;
      else if (!pwrgd_n)      cfg_q[g] <= cfg_strap[g];
      else if (cfg_wr_en[g])  cfg_q[g] <= cfg_wr_val[g];
    end

    // R6: during the power-on window the bit tracks its strap
    p_cfg_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pwrgd_n |=> (cfg_q[g] == $past(cfg_strap[g])));
  end

  // R1: latched straps move only when the strobe was low
  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwrgd_n) |-> $stable(strap_q));
endmodule

// File: rtl/fsel_arbiter.sv
module fsel_arbiter
  import fsel_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  boot_load,
  input  logic  upd,
  input  logic  wd_timeout,
  input  logic  sw_en,
  input  code_t sw_code,
  input  logic  safe_en,
  input  code_t safe_code,
  input  code_t strap_q,
  input  logic  err_clr,
  output code_t act_code,
  output logic  code_err,
  output logic  cand_rsvd
);
  code_t cand;
  logic  load;

  always_comb begin
    if (wd_timeout)     cand = safe_en ? safe_code : strap_q;
    else if (boot_load) cand = strap_q;
    else                cand = sw_en ? sw_code : strap_q;
  end

  assign load      = wd_timeout || boot_load || upd;
  assign cand_rsvd = code_reserved(cand);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= '0;
      code_err <= 1'b0;
    end else begin
      if (load && cand_rsvd)   code_err <= 1'b1;
      else if (err_clr)        code_err <= 1'b0;
      if (load && !cand_rsvd)  act_code <= cand;
    end
  end

  // R4: a reserved code never becomes active
  p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !code_reserved(act_code));
  // R5: raising the error leaves the previous code in place
  p_err_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_err) |-> $stable(act_code));
  // R10: no load event, no change
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd || wd_timeout || boot_load) |=> $stable(act_code));
endmodule

// File: rtl/fsel_direct.sv
module fsel_direct #(
  parameter int M_W = 7,
  parameter int N_W = 10,
  localparam int NUM_W = N_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_wr_en,
  input  logic             dp_wr_val,
  input  logic             wd_timeout,
  input  logic             upd,
  input  logic [M_W-1:0]   m_val,
  input  logic [N_W-1:0]   n_val,
  output logic             direct_en,
  output logic [NUM_W-1:0] pll_num,
  output logic [M_W-1:0]   pll_den
);
  localparam logic [NUM_W-1:0] N_OFS = NUM_W'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      direct_en <= 1'b0;
      pll_num   <= '0;
      pll_den   <= '0;
    end else if (wd_timeout) begin
      direct_en <= 1'b0;
      pll_num   <= '0;
      pll_den   <= '0;
    end else begin
      if (dp_wr_en) direct_en <= dp_wr_val;
      if (upd && direct_en) begin
        pll_num <= {1'b0, n_val} + N_OFS;
        pll_den <= m_val;
      end
    end
  end

  // R7: timeout cancels direct programming
  p_wd_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_timeout |=> (!direct_en && pll_num == '0 && pll_den == '0));
  // R8: captured values move only on an update in direct mode or a timeout
  p_mn_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !((upd && direct_en) || wd_timeout) |=> $stable(pll_num));
endmodule

// File: rtl/fsel_div_decode.sv
module fsel_div_decode
  import fsel_pkg::*;
(
  input  code_t             code,
  output logic [DIV_W-1:0]  cpu_div,
  output logic [TRIM_W-1:0] trim_sel
);
  assign cpu_div  = cpu_ratio(code);
  assign trim_sel = trim_of(code);
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import fsel_pkg::*;
#(
  parameter int M_W = 7,
  parameter int N_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwrgd_n,
  input  logic [4:0]     strap_fs,
  input  logic           strap_mode,
  input  logic           strap_sel24,
  input  logic           mode_wr_en,
  input  logic           mode_wr_val,
  input  logic           sel24_wr_en,
  input  logic           sel24_wr_val,
  input  logic           sw_en,
  input  logic [4:0]     sw_code,
  input  logic           safe_en,
  input  logic [4:0]     safe_code,
  input  logic           upd,
  input  logic           wd_timeout,
  input  logic           err_clr,
  input  logic           dp_wr_en,
  input  logic           dp_wr_val,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_val,
  output logic [4:0]     act_code,
  output logic [3:0]     cpu_div,
  output logic [1:0]     trim_sel,
  output logic           code_err,
  output logic           sel_rsvd,
  output logic [4:0]     strap_rb,
  output logic           mode_bit,
  output logic           sel24_bit,
  output logic           direct_en,
  output logic [N_W:0]   pll_num,
  output logic [M_W-1:0] pll_den
);
  logic [1:0] cfg_q;
  logic       boot_load;
  code_t      strap_q;

  fsel_strap_latch #(.NCFG(2)) u_strap (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_fs(strap_fs),
    .cfg_strap({strap_sel24, strap_mode}),
    .cfg_wr_en({sel24_wr_en, mode_wr_en}),
    .cfg_wr_val({sel24_wr_val, mode_wr_val}),
    .strap_q(strap_q), .cfg_q(cfg_q), .boot_load(boot_load)
  );

  fsel_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .boot_load(boot_load), .upd(upd),
    .wd_timeout(wd_timeout), .sw_en(sw_en), .sw_code(sw_code),
    .safe_en(safe_en), .safe_code(safe_code), .strap_q(strap_q),
    .err_clr(err_clr), .act_code(act_code), .code_err(code_err),
    .cand_rsvd(sel_rsvd)
  );

  fsel_direct #(.M_W(M_W), .N_W(N_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .dp_wr_en(dp_wr_en), .dp_wr_val(dp_wr_val),
    .wd_timeout(wd_timeout), .upd(upd), .m_val(m_val), .n_val(n_val),
    .direct_en(direct_en), .pll_num(pll_num), .pll_den(pll_den)
  );

  fsel_div_decode u_dec (
    .code(act_code), .cpu_div(cpu_div), .trim_sel(trim_sel)
  );

  assign strap_rb  = strap_q;
  assign mode_bit  = cfg_q[0];
  assign sel24_bit = cfg_q[1];
endmodule

// File: tb/fsel_ctrl_tb.sv
module fsel_ctrl_tb;
  logic clk = 0, rst_n = 0, pwrgd_n = 0;
  logic [4:0] strap_fs = 0, sw_code = 0, safe_code = 0;
  logic strap_mode = 0, strap_sel24 = 0, mode_wr_en = 0, mode_wr_val = 0;
  logic sel24_wr_en = 0, sel24_wr_val = 0, sw_en = 0, safe_en = 0;
  logic upd = 0, wd_timeout = 0, err_clr = 0, dp_wr_en = 0, dp_wr_val = 0;
  logic [6:0] m_val = 0;
  logic [9:0] n_val = 0;
  logic [4:0] act_code, strap_rb;
  logic [3:0] cpu_div;
  logic [1:0] trim_sel;
  logic code_err, sel_rsvd, mode_bit, sel24_bit, direct_en;
  logic [10:0] pll_num;
  logic [6:0] pll_den;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fsel_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one rising edge carries the strobes set here
  task automatic pulse(input logic u, input logic w, input logic c);
    @(negedge clk); upd = u; wd_timeout = w; err_clr = c;
    @(negedge clk); upd = 0; wd_timeout = 0; err_clr = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R10 reset act_code", act_code, 0);
    chk("R5 reset code_err", code_err, 0);
    chk("R8 reset direct_en", direct_en, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_boot;
    strap_fs = 5'b00101; strap_mode = 1; strap_sel24 = 1;
    repeat (3) @(negedge clk);
    mode_wr_en = 1; mode_wr_val = 0;
    @(negedge clk); mode_wr_en = 0;
    chk("R6 write ignored in power-on window", mode_bit, 1);
    chk("R6 sel24 follows strap", sel24_bit, 1);
    chk("R10 no load before release", act_code, 0);
    pwrgd_n = 1;
    @(negedge clk);
    chk("R2 boot load of straps", act_code, 5'b00101);
    chk("R9 cpu_div for 101", cpu_div, 2);
    strap_fs = 5'b00000;
    repeat (3) @(negedge clk);
    chk("R1 straps held after release", strap_rb, 5'b00101);
  endtask

  task automatic t_sw;
    sw_en = 1; sw_code = 5'b01010;
    repeat (3) @(negedge clk);
    chk("R10 no change without strobe", act_code, 5'b00101);
    pulse(1, 0, 0);
    chk("R3 software code applied", act_code, 5'b01010);
    chk("R9 cpu_div for 010", cpu_div, 6);
    chk("R9 trim group 1", trim_sel, 1);
  endtask

  task automatic t_rsvd;
    sw_code = 5'b01100;
    @(negedge clk);
    chk("R5 sel_rsvd live", sel_rsvd, 1);
    pulse(1, 0, 0);
    chk("R4 reserved 01100 kept old", act_code, 5'b01010);
    chk("R5 sticky error set", code_err, 1);
    pulse(1, 0, 1);
    chk("R5 set wins over clear", code_err, 1);
    sw_code = 5'b00011;
    pulse(1, 0, 0);
    chk("R4 reserved 00011 kept old", act_code, 5'b01010);
    pulse(0, 0, 1);
    chk("R5 error cleared", code_err, 0);
    sw_code = 5'b11000;
    pulse(1, 0, 0);
    chk("R4 legal 11000 applied", act_code, 5'b11000);
    chk("R9 trim group 2", trim_sel, 2);
    chk("R9 cpu_div for 000", cpu_div, 8);
  endtask

  task automatic t_strap_src;
    sw_en = 0;
    pulse(1, 0, 0);
    chk("R3 strap source on update", act_code, 5'b00101);
    mode_wr_en = 1; mode_wr_val = 0;
    @(negedge clk); mode_wr_en = 0;
    chk("R6 write after window", mode_bit, 0);
  endtask

  task automatic t_direct;
    dp_wr_en = 1; dp_wr_val = 1;
    @(negedge clk); dp_wr_en = 0;
    m_val = 7'd48; n_val = 10'd300;
    pulse(1, 0, 0);
    chk("R8 direct_en", direct_en, 1);
    chk("R8 pll_num N+4", pll_num, 304);
    chk("R8 pll_den M", pll_den, 48);
  endtask

  task automatic t_wdog;
    safe_en = 1; safe_code = 5'b00010; sw_en = 1; sw_code = 5'b01001;
    pulse(1, 1, 0);
    chk("R7 safe code wins over update", act_code, 5'b00010);
    chk("R7 direct_en cleared", direct_en, 0);
    chk("R7 pll_num cleared", pll_num, 0);
    safe_en = 0;
    pulse(0, 1, 0);
    chk("R7 strap fallback", act_code, 5'b00101);
    safe_en = 1; safe_code = 5'b01111;
    pulse(0, 1, 0);
    chk("R7 reserved safe code rejected", act_code, 5'b00101);
    chk("R5 error on reserved fallback", code_err, 1);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_boot();
    t_sw();
    t_rsvd();
    t_strap_src();
    t_direct();
    t_wdog();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule